// File: doc/BRIEF.md
# Processor Reset Sequencer

This block drives the reset pins of a host processor from a single system clock. It produces two active-low resets: a power-on reset and a system reset. When the supply is reported good, it runs a cold sequence. Both resets are held low, then the power-on reset is released, and a short time later the system reset is released. Once a cold sequence has ended with the processor's PLL locked, a request input can start a warm sequence. A warm sequence leaves the power-on reset high and pulses only the system reset low.

During each sequence the block drives a configuration word onto the shared strap bus so that the processor can sample it at reset release. The word is captured when the sequence starts. The bus is driven from the first hold cycle until the PLL lock input is seen high. If lock does not arrive within the allowed window, the block raises a sticky error and stops driving the bus.

All timings are given in nanoseconds and converted to clock cycles at elaboration. Losing power-good at any moment aborts whatever is running and forces a fresh cold sequence.

Top module: `cpu_reset_sequencer`

## Requirements
- R1: While `rst_n` is low, and afterwards for as long as `pwr_good` stays low, `por_rst_n`, `sys_rst_n`, `strap_oe`, `busy` and `timeout_err` are all 0 and `strap_bus` is all zeros.
- R2: When `pwr_good` is sampled high with the block off, a cold sequence begins on the next cycle. Both resets stay low and `busy` is 1 for exactly HOLD cycles, where HOLD is the larger of the cold-hold time and the strap-setup time, each converted to cycles.
- R3: `por_rst_n` rises first. `sys_rst_n` rises exactly STAGGER cycles later. `sys_rst_n` is never 1 while `por_rst_n` is 0.
- R4: `strap_oe` is 1 from the first hold cycle until PLL lock is accepted. While `strap_oe` is 1, `strap_bus` holds the value `cfg_word` had on the clock edge that started the sequence; later changes of `cfg_word` have no effect. While `strap_oe` is 0, `strap_bus` is zero.
- R5: A high `pll_lock` sampled during the lock wait ends the sequence. On the next cycle `strap_oe` and `busy` are 0, both resets are 1, and the cold-complete condition is recorded.
- R6: If `pll_lock` has not been sampled high by the last cycle of the LOCK window, counted from the first cycle with `sys_rst_n` high, then on the next cycle `timeout_err` becomes 1, `strap_oe` and `busy` drop to 0, and both resets stay 1. `timeout_err` then stays 1 until `rst_n`.
- R7: In the idle state after a completed cold sequence, a `warm_req` pulse holds `sys_rst_n` low for exactly WARM cycles while `por_rst_n` stays 1. The lock wait of R5 and R6 follows.
- R8: `warm_req` is ignored while a sequence is running, while `pwr_good` is low, and in idle when no cold sequence has completed since power-good last rose.
- R9: When `pwr_good` is sampled low in any state, on the next cycle both resets, `strap_oe` and `busy` are 0, and the cold-complete condition is cleared.
- R10: Each nanosecond limit becomes ceil(ns / CLK_PERIOD_NS) cycles, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| pwr_good | input | 1 | Supply stable indication |
| warm_req | input | 1 | Request for a warm reset sequence |
| pll_lock | input | 1 | PLL lock output of the processor |
| cfg_word | input | CFG_W | Configuration strap value to present |
| por_rst_n | output | 1 | Power-on reset to the processor, active low |
| sys_rst_n | output | 1 | System reset to the processor, active low |
| strap_bus | output | CFG_W | Strap value, zero when not driven |
| strap_oe | output | 1 | Output enable for the strap bus |
| busy | output | 1 | A reset sequence is in progress |
| timeout_err | output | 1 | Sticky flag for a missed PLL lock |

## Verification
The bench uses a 20 ns clock with a 310 ns cold hold and a 30 ns stagger. These round up to 16 and 2 cycles, so the ceiling conversion and a multi-cycle gap between the two reset releases are both visible. A 500 ns warm hold (25 cycles) and a 1500 ns lock window (75 cycles) keep whole sequences short. That allows the run to reach a lock arriving in the very last cycle of the window, a lock arriving in the first cycle, timeouts after both cold and warm sequences, and a power loss in the middle of a warm hold, all in one run.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/1ps
package rst_seq_pkg;

    typedef enum logic [2:0] {
        SQ_OFF,
        SQ_COLD_HOLD,
        SQ_STAGGER,
        SQ_LOCK_WAIT,
        SQ_IDLE,
        SQ_WARM_HOLD
    } seq_state_e;

    typedef struct packed {
        logic por_n;
        logic sys_n;
        logic strap_oe;
        logic busy;
    } pin_drive_t;

    // ceil(ns / period), never below one cycle
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ns);
        int unsigned c;
        c = (ns + period_ns - 1) / period_ns;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rst_seq_timer.sv
`timescale 1ns/1ps
module rst_seq_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = load_val;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired = (tmr_q.cnt == '0);

    // R10
    tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tmr_q.cnt != '0) |=> (tmr_q.cnt == $past(tmr_q.cnt) - CNT_W'(1)));

    // R10
    tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (tmr_q.cnt == $past(load_val)));

endmodule

// File: rtl/rst_seq_strap.sv
`timescale 1ns/1ps
module rst_seq_strap #(
    parameter int unsigned CFG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             oe,
    output logic [CFG_W-1:0] strap_bus
);

    typedef struct packed {
        logic [CFG_W-1:0] word;
    } strap_t;

    strap_t strap_d, strap_q;

    always_comb begin
        strap_d = strap_q;
        if (capture) strap_d.word = cfg_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strap_q <= '0;
        else        strap_q <= strap_d;
    end

    assign strap_bus = oe ? strap_q.word : '0;

    // R4
    strap_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && $past(oe)) |-> $stable(strap_bus));

    // R4
    strap_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (strap_bus == '0));

endmodule

// File: rtl/rst_seq_fsm.sv
`timescale 1ns/1ps
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned HOLD_CYC = 100,
    parameter int unsigned STAG_CYC = 1,
    parameter int unsigned WARM_CYC = 25,
    parameter int unsigned LOCK_CYC = 75
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good,
    input  logic             warm_req,
    input  logic             pll_lock,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             strap_capture,
    output pin_drive_t       drv,
    output logic             timeout_err
);

    typedef struct packed {
        seq_state_e st;
        logic       cold_done;
        logic       err;
    } fsm_t;

    localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] STAG_LD = CNT_W'(STAG_CYC - 1);
    localparam logic [CNT_W-1:0] WARM_LD = CNT_W'(WARM_CYC - 1);
    localparam logic [CNT_W-1:0] LOCK_LD = CNT_W'(LOCK_CYC - 1);

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d         = fsm_q;
        tmr_load      = 1'b0;
        tmr_val       = '0;
        strap_capture = 1'b0;
        if (!pwr_good) begin
            fsm_d.st        = SQ_OFF;
            fsm_d.cold_done = 1'b0;
        end else begin
            case (fsm_q.st)
                SQ_OFF: begin
                    fsm_d.st      = SQ_COLD_HOLD;
                    tmr_load      = 1'b1;
                    tmr_val       = HOLD_LD;
                    strap_capture = 1'b1;
                end
                SQ_COLD_HOLD: begin
                    if (tmr_expired) begin
                        fsm_d.st = SQ_STAGGER;
                        tmr_load = 1'b1;
                        tmr_val  = STAG_LD;
                    end
                end
                SQ_STAGGER: begin
                    if (tmr_expired) begin
                        fsm_d.st = SQ_LOCK_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = LOCK_LD;
                    end
                end
                SQ_LOCK_WAIT: begin
                    if (pll_lock) begin
                        fsm_d.st        = SQ_IDLE;
                        fsm_d.cold_done = 1'b1;
                    end else if (tmr_expired) begin
                        fsm_d.st  = SQ_IDLE;
                        fsm_d.err = 1'b1;
                    end
                end
                SQ_IDLE: begin
                    if (warm_req && fsm_q.cold_done) begin
                        fsm_d.st      = SQ_WARM_HOLD;
                        tmr_load      = 1'b1;
                        tmr_val       = WARM_LD;
                        strap_capture = 1'b1;
                    end
                end
                SQ_WARM_HOLD: begin
                    if (tmr_expired) begin
                        fsm_d.st = SQ_LOCK_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = LOCK_LD;
                    end
                end
                default: fsm_d.st = SQ_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st        <= SQ_OFF;
            fsm_q.cold_done <= 1'b0;
            fsm_q.err       <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    // Moore decode of the pin levels from the registered state
    always_comb begin
        drv = '{por_n: 1'b0, sys_n: 1'b0, strap_oe: 1'b0, busy: 1'b0};
        case (fsm_q.st)
            SQ_COLD_HOLD: drv = '{por_n: 1'b0, sys_n: 1'b0, strap_oe: 1'b1, busy: 1'b1};
            SQ_STAGGER:   drv = '{por_n: 1'b1, sys_n: 1'b0, strap_oe: 1'b1, busy: 1'b1};
            SQ_LOCK_WAIT: drv = '{por_n: 1'b1, sys_n: 1'b1, strap_oe: 1'b1, busy: 1'b1};
            SQ_IDLE:      drv = '{por_n: 1'b1, sys_n: 1'b1, strap_oe: 1'b0, busy: 1'b0};
            SQ_WARM_HOLD: drv = '{por_n: 1'b1, sys_n: 1'b0, strap_oe: 1'b1, busy: 1'b1};
            default:      drv = '{por_n: 1'b0, sys_n: 1'b0, strap_oe: 1'b0, busy: 1'b0};
        endcase
    end

    assign timeout_err = fsm_q.err;

    // R8
    warm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == SQ_IDLE && pwr_good && warm_req && !fsm_q.cold_done) |=> (fsm_q.st == SQ_IDLE));

    // R7
    warm_after_cold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == SQ_WARM_HOLD) |-> fsm_q.cold_done);

    // R5
    lock_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == SQ_LOCK_WAIT && pwr_good && pll_lock) |=> (fsm_q.st == SQ_IDLE && fsm_q.cold_done));

    // R9
    power_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (fsm_q.st == SQ_OFF && !fsm_q.cold_done));

endmodule

// File: rtl/cpu_reset_sequencer.sv
`timescale 1ns/1ps
module cpu_reset_sequencer
    import rst_seq_pkg::*;
#(
    parameter int unsigned CFG_W          = 24,
    parameter int unsigned CLK_PERIOD_NS  = 20,
    parameter int unsigned COLD_HOLD_NS   = 2000,
    parameter int unsigned STAGGER_NS     = 10,
    parameter int unsigned WARM_HOLD_NS   = 500,
    parameter int unsigned LOCK_MAX_NS    = 1500,
    parameter int unsigned STRAP_SETUP_NS = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good,
    input  logic             warm_req,
    input  logic             pll_lock,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             por_rst_n,
    output logic             sys_rst_n,
    output logic [CFG_W-1:0] strap_bus,
    output logic             strap_oe,
    output logic             busy,
    output logic             timeout_err
);

    localparam int unsigned SETUP_CYC = ns_to_cyc(STRAP_SETUP_NS, CLK_PERIOD_NS);
    localparam int unsigned HOLD_CYC  = max_u(ns_to_cyc(COLD_HOLD_NS, CLK_PERIOD_NS), SETUP_CYC);
    localparam int unsigned STAG_CYC  = ns_to_cyc(STAGGER_NS, CLK_PERIOD_NS);
    localparam int unsigned WARM_CYC  = max_u(ns_to_cyc(WARM_HOLD_NS, CLK_PERIOD_NS), SETUP_CYC);
    localparam int unsigned LOCK_CYC  = ns_to_cyc(LOCK_MAX_NS, CLK_PERIOD_NS);
    localparam int unsigned MAX_CYC   = max_u(max_u(HOLD_CYC, WARM_CYC), max_u(STAG_CYC, LOCK_CYC));
    localparam int unsigned CNT_W     = max_u($clog2(MAX_CYC + 1), 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             strap_capture;
    pin_drive_t       drv;

    rst_seq_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    rst_seq_fsm #(
        .CNT_W    (CNT_W),
        .HOLD_CYC (HOLD_CYC),
        .STAG_CYC (STAG_CYC),
        .WARM_CYC (WARM_CYC),
        .LOCK_CYC (LOCK_CYC)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_good      (pwr_good),
        .warm_req      (warm_req),
        .pll_lock      (pll_lock),
        .tmr_expired   (tmr_expired),
        .tmr_load      (tmr_load),
        .tmr_val       (tmr_val),
        .strap_capture (strap_capture),
        .drv           (drv),
        .timeout_err   (timeout_err)
    );

    rst_seq_strap #(
        .CFG_W (CFG_W)
    ) u_strap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (strap_capture),
        .cfg_word  (cfg_word),
        .oe        (drv.strap_oe),
        .strap_bus (strap_bus)
    );

    assign por_rst_n = drv.por_n;
    assign sys_rst_n = drv.sys_n;
    assign strap_oe  = drv.strap_oe;
    assign busy      = drv.busy;

    // R3
    por_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !por_rst_n |-> !sys_rst_n);

    // R3
    release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> $past(por_rst_n));

    // R4
    strap_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> ($past(strap_oe) && strap_oe));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> timeout_err);

    // R9
    power_drop_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (!por_rst_n && !sys_rst_n && !strap_oe && !busy));

endmodule

// File: tb/cpu_reset_sequencer_test.sv
`timescale 1ns/1ps
module cpu_reset_sequencer_test;

    localparam int CFG_W    = 24;
    localparam int PER      = 20;
    localparam int COLD_NS  = 310;
    localparam int STAG_NS  = 30;
    localparam int WARM_NS  = 500;
    localparam int LOCK_NS  = 1500;
    localparam int SETUP_NS = 50;
    localparam int WDOG     = 20000;

    function automatic int cyc_of(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int H  = (cyc_of(COLD_NS) > cyc_of(SETUP_NS)) ? cyc_of(COLD_NS) : cyc_of(SETUP_NS);
    localparam int S  = cyc_of(STAG_NS);
    localparam int WM = (cyc_of(WARM_NS) > cyc_of(SETUP_NS)) ? cyc_of(WARM_NS) : cyc_of(SETUP_NS);
    localparam int L  = cyc_of(LOCK_NS);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             pwr_good;
    logic             warm_req;
    logic             pll_lock;
    logic [CFG_W-1:0] cfg_word;
    logic             por_rst_n;
    logic             sys_rst_n;
    logic [CFG_W-1:0] strap_bus;
    logic             strap_oe;
    logic             busy;
    logic             timeout_err;

    int cyc   = 0;
    int n_vec = 0;
    int n_bad = 0;

    typedef struct packed {
        int               cyc;
        logic             por;
        logic             sys;
        logic             oe;
        logic             busy;
        logic             err;
        logic [CFG_W-1:0] bus;
    } exp_t;

    exp_t  exp_q[$];
    string req_q[$];

    cpu_reset_sequencer #(
        .CFG_W          (CFG_W),
        .CLK_PERIOD_NS  (PER),
        .COLD_HOLD_NS   (COLD_NS),
        .STAGGER_NS     (STAG_NS),
        .WARM_HOLD_NS   (WARM_NS),
        .LOCK_MAX_NS    (LOCK_NS),
        .STRAP_SETUP_NS (SETUP_NS)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_good    (pwr_good),
        .warm_req    (warm_req),
        .pll_lock    (pll_lock),
        .cfg_word    (cfg_word),
        .por_rst_n   (por_rst_n),
        .sys_rst_n   (sys_rst_n),
        .strap_bus   (strap_bus),
        .strap_oe    (strap_oe),
        .busy        (busy),
        .timeout_err (timeout_err)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int c, input logic p, input logic s, input logic o,
                             input logic b, input logic e, input logic [CFG_W-1:0] bus,
                             input string r);
        exp_t x;
        x.cyc = c; x.por = p; x.sys = s; x.oe = o; x.busy = b; x.err = e; x.bus = bus;
        exp_q.push_back(x);
        req_q.push_back(r);
    endtask

    // monitor: compares the outputs with the queued expectation of this cycle
    always @(negedge clk) begin : monitor
        exp_t  e;
        string r;
        while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
            e = exp_q.pop_front();
            r = req_q.pop_front();
            n_vec++;
            if (e.cyc != cyc ||
                {por_rst_n, sys_rst_n, strap_oe, busy, timeout_err, strap_bus} !==
                {e.por, e.sys, e.oe, e.busy, e.err, e.bus}) begin
                n_bad++;
                $display("FAIL %s cycle %0d: actual por=%b sys=%b oe=%b busy=%b err=%b bus=%h, expected por=%b sys=%b oe=%b busy=%b err=%b bus=%h (for cycle %0d)",
                         r, cyc, por_rst_n, sys_rst_n, strap_oe, busy, timeout_err, strap_bus,
                         e.por, e.sys, e.oe, e.busy, e.err, e.bus, e.cyc);
            end
        end
    end

    task automatic go_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic push_lock(input int w, input int lock_at, input logic e0, input logic [CFG_W-1:0] cfg);
        if (lock_at >= 0) begin
            expect_at(w + lock_at + 1, 1, 1, 0, 0, e0, '0, "R5");
            expect_at(w + lock_at + 3, 1, 1, 0, 0, e0, '0, "R5");
        end else begin
            expect_at(w + L - 1, 1, 1, 1, 1, e0, cfg, "R6");
            expect_at(w + L,     1, 1, 0, 0, 1,  '0,  "R6");
            expect_at(w + L + 2, 1, 1, 0, 0, 1,  '0,  "R6");
        end
    endtask

    task automatic drive_lock(input int w, input int lock_at);
        if (lock_at >= 0) begin
            go_to(w + lock_at);
            pll_lock = 1'b1;
            go_to(w + lock_at + 4);
        end else begin
            go_to(w + L + 3);
        end
    endtask

    // cold sequence from the off state; a warm pulse during the hold must be ignored
    task automatic cold_seq(input logic [CFG_W-1:0] cfg, input int lock_at, input logic e0);
        int c;
        int w;
        c = cyc;
        w = c + H + S + 1;
        pll_lock = 1'b0;
        cfg_word = cfg;
        pwr_good = 1'b1;
        expect_at(c + 1,     0, 0, 1, 1, e0, cfg, "R2");
        expect_at(c + H,     0, 0, 1, 1, e0, cfg, "R2");
        expect_at(c + H + 1, 1, 0, 1, 1, e0, cfg, "R10");
        expect_at(c + H + S, 1, 0, 1, 1, e0, cfg, "R3");
        expect_at(w,         1, 1, 1, 1, e0, cfg, "R4");
        push_lock(w, lock_at, e0, cfg);
        go_to(c + 2);
        cfg_word = ~cfg;
        warm_req = 1'b1;
        go_to(c + 3);
        warm_req = 1'b0;
        drive_lock(w, lock_at);
    endtask

    task automatic warm_seq(input logic [CFG_W-1:0] cfg, input int lock_at, input logic e0);
        int c;
        int w;
        c = cyc;
        w = c + WM + 1;
        pll_lock = 1'b0;
        cfg_word = cfg;
        warm_req = 1'b1;
        expect_at(c + 1,      1, 0, 1, 1, e0, cfg, "R7");
        expect_at(c + WM / 2, 1, 0, 1, 1, e0, cfg, "R7");
        expect_at(c + WM,     1, 0, 1, 1, e0, cfg, "R7");
        expect_at(w,          1, 1, 1, 1, e0, cfg, "R7");
        push_lock(w, lock_at, e0, cfg);
        go_to(c + 1);
        warm_req = 1'b0;
        cfg_word = ~cfg;
        drive_lock(w, lock_at);
    endtask

    task automatic warm_ignored(input logic e0);
        int c;
        c = cyc;
        warm_req = 1'b1;
        expect_at(c + 1, 1, 1, 0, 0, e0, '0, "R8");
        expect_at(c + 3, 1, 1, 0, 0, e0, '0, "R8");
        go_to(c + 1);
        warm_req = 1'b0;
        go_to(c + 4);
    endtask

    task automatic power_loss(input logic e0);
        int c;
        c = cyc;
        pwr_good = 1'b0;
        pll_lock = 1'b0;
        expect_at(c + 1, 0, 0, 0, 0, e0, '0, "R9");
        expect_at(c + 4, 0, 0, 0, 0, e0, '0, "R8");
        go_to(c + 2);
        warm_req = 1'b1;
        go_to(c + 3);
        warm_req = 1'b0;
        go_to(c + 5);
    endtask

    initial begin : driver
        int c;
        rst_n    = 1'b0;
        pwr_good = 1'b0;
        warm_req = 1'b0;
        pll_lock = 1'b0;
        cfg_word = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        c = cyc;
        // R1: reset state, held while power is not good, warm request ignored (R8)
        expect_at(c + 1, 0, 0, 0, 0, 0, '0, "R1");
        expect_at(c + 5, 0, 0, 0, 0, 0, '0, "R1");
        go_to(c + 2);
        warm_req = 1'b1;
        go_to(c + 3);
        warm_req = 1'b0;
        go_to(c + 6);

        cold_seq(24'hA5C319, 36, 1'b0);       // typical lock
        warm_seq(24'h3C0FF0, 10, 1'b0);       // warm with lock
        warm_seq(24'h123456, -1, 1'b0);       // warm lock timeout
        warm_seq(24'h654321, L - 1, 1'b1);    // lock in last cycle of window, error stays

        // power loss in the middle of a warm hold
        c = cyc;
        pll_lock = 1'b0;
        cfg_word = 24'h0BEEF0;
        warm_req = 1'b1;
        expect_at(c + 1, 1, 0, 1, 1, 1, 24'h0BEEF0, "R7");
        expect_at(c + 5, 1, 0, 1, 1, 1, 24'h0BEEF0, "R9");
        go_to(c + 1);
        warm_req = 1'b0;
        go_to(c + 5);
        power_loss(1'b1);

        cold_seq(24'hFF0001, -1, 1'b1);       // cold lock timeout, no completed cold
        warm_ignored(1'b1);
        power_loss(1'b1);
        cold_seq(24'h008001, 0, 1'b1);        // lock in the first wait cycle
        warm_seq(24'hC0FFEE, 5, 1'b1);

        go_to(cyc + 3);
        if (exp_q.size() != 0) begin
            n_vec++;
            n_bad++;
            $display("FAIL R1 pending expectations: actual %0d left, expected 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (WDOG) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual cycle %0d reached, expected end before %0d", cyc, WDOG);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule